// File: doc/BRIEF.md
# Eight-Bit Stack-Machine Processor Core

This block is a small multicycle processor with an 8-bit datapath. It has eight general registers and a unified 256-byte memory that holds both program and data. Instructions are one to three bytes long. The core fetches an opcode, then two following bytes, and then executes. It supports immediate loads, add and multiply, compare with flag-based branches, an unconditional jump, a downward-growing stack for push, pop, call and return, an output strobe that publishes a register value, and halt.

The memory sits inside the block. While reset is held low, a byte-wide write port fills it with a program. When reset is released, execution starts at address 0. The core runs until it reaches a halt instruction or an opcode it does not know. It then parks and reports its state on two status outputs.

Top module: `byte_core`

## Requirements
- R1: During and right after reset, the PC is 0, registers 0 to 6 hold 0, register 7 (the stack pointer) holds 0xF4, the compare flags are clear, and halted, illegal and out_valid are low. The load port writes memory only while rst_n is low.
- R2: LDI (0x82) copies the third instruction byte into the register whose index (0 to 7) is the second byte. PRN (0x47) raises out_valid for exactly one cycle, with out_data equal to the named register. LDI, ADD, MUL and CMP advance the PC by 3. PRN, PUSH and POP advance it by 2.
- R3: ADD (0xA0) and MUL (0xA2) combine the registers named by the second and third bytes. They write the result, modulo 256, into the register named by the second byte.
- R4: CMP (0xA7) clears the less, greater and equal flags and then sets exactly one of them. JEQ (0x55) loads the PC from the named register when equal is 1. JNE (0x56) does so when equal is 0. A branch that is not taken advances the PC by 2.
- R5: PUSH (0x45) decrements register 7 and then stores the named register at that address. POP (0x46) loads the named register from the address in register 7 and then increments register 7. Stack traffic is last-in first-out.
- R6: CALL (0x50) pushes the address of the following instruction (PC+2) and jumps to the named register's value. RET (0x11) pops the stack into the PC.
- R7: JMP (0x54) loads the PC from the named register.
- R8: HLT (0x01) sets halted. The core then executes nothing further, so halted stays high and out_valid stays low until reset.
- R9: Any opcode not listed above sets both illegal and halted, and nothing after it executes.
- R10: Every instruction takes 4 cycles (fetch, two operand reads, execute), except POP and RET, which take 5. Two back-to-back PRN instructions give out_valid pulses 4 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; also enables the load port |
| load_we | input | 1 | Memory preload write strobe (honoured only while rst_n is low) |
| load_addr | input | 8 | Memory preload address |
| load_data | input | 8 | Memory preload byte |
| out_valid | output | 1 | One-cycle strobe from PRN |
| out_data | output | 8 | Register value published by PRN |
| halted | output | 1 | Core has stopped (HLT or unknown opcode) |
| illegal | output | 1 | Core stopped on an unknown opcode |

## Verification
The assertions take for granted that programs are well formed:
- POP never names register 7.
- No instruction writes over its own operand bytes while they are being fetched.
- The stack pointer does not wrap across the program area.

Under those assumptions, the PC step, stack pointer movement, flag exclusivity and halt stickiness all follow from the opcode alone. The stimulus keeps to them because every program is built in the bench with fixed layouts. These layouts keep the stack near 0xF4, keep code below address 40, and pop only into registers 0 to 6. Operand values sweep a grid that covers 0, 255 and the carry and wrap corners of add and multiply.

// File: rtl/byte_core_pkg.sv
package byte_core_pkg;

   // Opcode map: the top two bits give the number of operand bytes.
   localparam logic [7:0] OP_HLT  = 8'h01;
   localparam logic [7:0] OP_RET  = 8'h11;
   localparam logic [7:0] OP_PUSH = 8'h45;
   localparam logic [7:0] OP_POP  = 8'h46;
   localparam logic [7:0] OP_PRN  = 8'h47;
   localparam logic [7:0] OP_CALL = 8'h50;
   localparam logic [7:0] OP_JMP  = 8'h54;
   localparam logic [7:0] OP_JEQ  = 8'h55;
   localparam logic [7:0] OP_JNE  = 8'h56;
   localparam logic [7:0] OP_LDI  = 8'h82;
   localparam logic [7:0] OP_ADD  = 8'hA0;
   localparam logic [7:0] OP_MUL  = 8'hA2;
   localparam logic [7:0] OP_CMP  = 8'hA7;

   typedef enum logic [2:0] {
      ST_FETCH,
      ST_OPC,
      ST_OPA,
      ST_EXEC,
      ST_STACK,
      ST_STOP
   } core_state_t;

endpackage

// File: rtl/byte_core_mem.sv
module byte_core_mem #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
      rdata <= store[raddr];
   end

endmodule

// File: rtl/byte_core_regs.sv
module byte_core_regs #(
   parameter int                 DATA_W   = 8,
   parameter int                 NUM_REGS = 8,
   parameter int                 RIDX_W   = 3,
   parameter int                 SP_IDX   = 7,
   parameter logic [DATA_W-1:0]  SP_INIT  = 8'hF4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RIDX_W-1:0] rd_a_idx,
   input  logic [RIDX_W-1:0] rd_b_idx,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b,
   output logic [DATA_W-1:0] sp_val,
   input  logic              wr_en,
   input  logic [RIDX_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              sp_we,
   input  logic [DATA_W-1:0] sp_wdata
);
   localparam logic [RIDX_W-1:0] SP_SEL = RIDX_W'(SP_IDX);

   logic [NUM_REGS-1:0][DATA_W-1:0] regs_flat;

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      localparam logic [DATA_W-1:0] INIT_VAL = (r == SP_IDX) ? SP_INIT : '0;
      logic [DATA_W-1:0] q;
      if (r == SP_IDX) begin : g_sp
         // The stack-pointer port wins over the general port.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               q <= INIT_VAL;
            else if (sp_we)                           q <= sp_wdata;
            else if (wr_en && wr_idx == RIDX_W'(r))   q <= wr_data;
         end
      end else begin : g_gp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               q <= INIT_VAL;
            else if (wr_en && wr_idx == RIDX_W'(r))   q <= wr_data;
         end
      end
      assign regs_flat[r] = q;
   end

   assign rd_a   = regs_flat[rd_a_idx];
   assign rd_b   = regs_flat[rd_b_idx];
   assign sp_val = regs_flat[SP_IDX];

   AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sp_we && !(wr_en && wr_idx == SP_SEL)) |=> $stable(sp_val)); // R5

endmodule

// File: rtl/byte_core_alu.sv
module byte_core_alu #(
   parameter int DATA_W        = 8,
   parameter bit MUL_SHIFT_ADD = 1'b0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] sum,
   output logic [DATA_W-1:0] prod,
   output logic              lt,
   output logic              gt,
   output logic              eq
);
   assign sum = a + b;
   assign lt  = (a < b);
   assign gt  = (a > b);
   assign eq  = (a == b);

   if (MUL_SHIFT_ADD) begin : g_mul_sa
      always_comb begin
         prod = '0;
         for (int i = 0; i < DATA_W; i++) begin
            if (b[i]) prod = prod + (a << i);
         end
      end
   end else begin : g_mul_op
      assign prod = a * b;
   end

endmodule

// File: rtl/byte_core.sv
module byte_core
   import byte_core_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int ADDR_W        = 8,
   parameter int NUM_REGS      = 8,
   parameter int SP_INIT       = 'hF4,
   parameter bit MUL_SHIFT_ADD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_we,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [DATA_W-1:0] load_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              halted,
   output logic              illegal
);
   localparam int                RIDX_W  = $clog2(NUM_REGS);
   localparam int                SP_IDX  = NUM_REGS - 1;
   localparam logic [ADDR_W-1:0] PC_ONE  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] PC_TWO  = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] PC_THR  = ADDR_W'(3);
   localparam logic [DATA_W-1:0] D_ONE   = DATA_W'(1);

   if (DATA_W < 8) begin : g_bad_data_w
      $error("byte_core: DATA_W must hold an 8-bit opcode");
   end
   if (ADDR_W != DATA_W) begin : g_bad_addr_w
      $error("byte_core: return addresses live in data bytes, ADDR_W must equal DATA_W");
   end
   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("byte_core: NUM_REGS must be a power of two, at least 2");
   end

   core_state_t       state;
   logic [ADDR_W-1:0] pc;
   logic [7:0]        ir;
   logic [RIDX_W-1:0] ra_sel;
   logic              flag_lt, flag_gt, flag_eq;

   logic              core_we;
   logic [ADDR_W-1:0] core_waddr;
   logic [DATA_W-1:0] core_wdata;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr, mem_raddr;
   logic [DATA_W-1:0] mem_wdata, mem_rdata;

   logic [RIDX_W-1:0] rb_sel;
   logic [DATA_W-1:0] ra_val, rb_val, sp_val;
   logic              gw_en, sp_we;
   logic [DATA_W-1:0] gw_data, sp_wdata;

   logic [DATA_W-1:0] alu_sum, alu_prod;
   logic              alu_lt, alu_gt, alu_eq;

   // Preload owns the memory write port while reset is held.
   assign mem_we    = rst_n ? core_we    : load_we;
   assign mem_waddr = rst_n ? core_waddr : load_addr;
   assign mem_wdata = rst_n ? core_wdata : load_data;

   // In EXEC the third instruction byte is on the read data bus.
   assign rb_sel = mem_rdata[RIDX_W-1:0];

   byte_core_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .raddr (mem_raddr),
      .rdata (mem_rdata)
   );

   byte_core_regs #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS),
      .RIDX_W   (RIDX_W),
      .SP_IDX   (SP_IDX),
      .SP_INIT  (DATA_W'(SP_INIT))
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_idx (ra_sel),
      .rd_b_idx (rb_sel),
      .rd_a     (ra_val),
      .rd_b     (rb_val),
      .sp_val   (sp_val),
      .wr_en    (gw_en),
      .wr_idx   (ra_sel),
      .wr_data  (gw_data),
      .sp_we    (sp_we),
      .sp_wdata (sp_wdata)
   );

   byte_core_alu #(.DATA_W(DATA_W), .MUL_SHIFT_ADD(MUL_SHIFT_ADD)) i_alu (
      .a    (ra_val),
      .b    (rb_val),
      .sum  (alu_sum),
      .prod (alu_prod),
      .lt   (alu_lt),
      .gt   (alu_gt),
      .eq   (alu_eq)
   );

   // Read address, memory writes and register writes.
   always_comb begin
      mem_raddr  = pc;
      core_we    = 1'b0;
      core_waddr = ADDR_W'(sp_val - D_ONE);
      core_wdata = ra_val;
      gw_en      = 1'b0;
      gw_data    = mem_rdata;
      sp_we      = 1'b0;
      sp_wdata   = sp_val - D_ONE;
      case (state)
         ST_FETCH: mem_raddr = pc;
         ST_OPC:   mem_raddr = pc + PC_ONE;
         ST_OPA:   mem_raddr = pc + PC_TWO;
         ST_EXEC: begin
            mem_raddr = ADDR_W'(sp_val);
            case (ir)
               OP_LDI: begin gw_en = 1'b1; gw_data = mem_rdata; end
               OP_ADD: begin gw_en = 1'b1; gw_data = alu_sum;   end
               OP_MUL: begin gw_en = 1'b1; gw_data = alu_prod;  end
               OP_PUSH: begin
                  core_we = 1'b1;
                  sp_we   = 1'b1;
               end
               OP_CALL: begin
                  core_we    = 1'b1;
                  core_wdata = DATA_W'(pc + PC_TWO);
                  sp_we      = 1'b1;
               end
               default: ;
            endcase
         end
         ST_STACK: begin
            sp_we    = 1'b1;
            sp_wdata = sp_val + D_ONE;
            if (ir == OP_POP) begin
               gw_en   = 1'b1;
               gw_data = mem_rdata;
            end
         end
         default: ;
      endcase
   end

   // Sequencer, PC, flags and outputs.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_FETCH;
         pc        <= '0;
         ir        <= '0;
         ra_sel    <= '0;
         flag_lt   <= 1'b0;
         flag_gt   <= 1'b0;
         flag_eq   <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         halted    <= 1'b0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         case (state)
            ST_FETCH: state <= ST_OPC;
            ST_OPC: begin
               ir    <= mem_rdata[7:0];
               state <= ST_OPA;
            end
            ST_OPA: begin
               ra_sel <= mem_rdata[RIDX_W-1:0];
               state  <= ST_EXEC;
            end
            ST_EXEC: begin
               state <= ST_FETCH;
               case (ir)
                  OP_LDI, OP_ADD, OP_MUL: pc <= pc + PC_THR;
                  OP_CMP: begin
                     pc      <= pc + PC_THR;
                     flag_lt <= alu_lt;
                     flag_gt <= alu_gt;
                     flag_eq <= alu_eq;
                  end
                  OP_PRN: begin
                     out_valid <= 1'b1;
                     out_data  <= ra_val;
                     pc        <= pc + PC_TWO;
                  end
                  OP_PUSH: pc <= pc + PC_TWO;
                  OP_POP: begin
                     pc    <= pc + PC_TWO;
                     state <= ST_STACK;
                  end
                  OP_CALL: pc    <= ADDR_W'(ra_val);
                  OP_RET:  state <= ST_STACK;
                  OP_JMP:  pc    <= ADDR_W'(ra_val);
                  OP_JEQ:  pc    <= flag_eq  ? ADDR_W'(ra_val) : pc + PC_TWO;
                  OP_JNE:  pc    <= !flag_eq ? ADDR_W'(ra_val) : pc + PC_TWO;
                  OP_HLT: begin
                     halted <= 1'b1;
                     state  <= ST_STOP;
                  end
                  default: begin
                     halted  <= 1'b1;
                     illegal <= 1'b1;
                     state   <= ST_STOP;
                  end
               endcase
            end
            ST_STACK: begin
               state <= ST_FETCH;
               if (ir == OP_RET) pc <= ADDR_W'(mem_rdata);
            end
            default: state <= ST_STOP;
         endcase
      end
   end

   AST_PC_STEP3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && (ir == OP_LDI || ir == OP_ADD || ir == OP_MUL || ir == OP_CMP))
      |=> pc == $past(pc) + PC_THR); // R2
   AST_PRN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid); // R2
   AST_FLAGS_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flag_lt, flag_gt, flag_eq})); // R4
   AST_PUSH_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && (ir == OP_PUSH || ir == OP_CALL)) |=> sp_val == $past(sp_val) - D_ONE); // R5
   AST_POP_SP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_STACK) |=> sp_val == $past(sp_val) + D_ONE); // R5
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted && !out_valid); // R8
   AST_ILLEGAL_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> halted); // R9
   AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OPC) |=> state == ST_OPA); // R10

endmodule

// File: tb/test_byte_core.sv
module test_byte_core;
   localparam int WATCHDOG = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_we = 1'b0;
   logic [7:0] load_addr = '0;
   logic [7:0] load_data = '0;
   logic       out_valid;
   logic [7:0] out_data;
   logic       halted;
   logic       illegal;

   byte_core i_byte_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_we   (load_we),
      .load_addr (load_addr),
      .load_data (load_data),
      .out_valid (out_valid),
      .out_data  (out_data),
      .halted    (halted),
      .illegal   (illegal)
   );

   always #2 clk = ~clk;   // 4 ns period

   int         checks = 0;
   int         failures = 0;
   int         cyc = 0;
   bit         finished = 0;
   logic [7:0] prog [0:63];
   int         plen = 0;
   logic [7:0] cap_d [0:15];
   int         cap_c [0:15];
   int         cap_n = 0;

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n && out_valid && cap_n < 16) begin
         cap_d[cap_n] = out_data;
         cap_c[cap_n] = cyc;
         cap_n++;
      end
      if (cyc >= WATCHDOG && !finished) begin
         failures++;
         $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WATCHDOG);
         summary();
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic emit(input int b);
      prog[plen] = 8'(b);
      plen++;
   endtask

   task automatic run_prog(input bit chk_reset);
      @(negedge clk);
      rst_n = 1'b0;
      cap_n = 0;
      for (int i = 0; i < plen; i++) begin
         load_we   = 1'b1;
         load_addr = 8'(i);
         load_data = prog[i];
         @(negedge clk);
      end
      load_we = 1'b0;
      if (chk_reset) begin
         check("R1 halted in reset", halted, 0);
         check("R1 illegal in reset", illegal, 0);
         check("R1 out_valid in reset", out_valid, 0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      if (chk_reset) check("R1 halted after release", halted, 0);
      for (int t = 0; t < 2000 && !halted; t++) @(negedge clk);
      check("R8 program reaches halt", halted, 1);
      repeat (12) @(negedge clk);
   endtask

   initial begin
      // R1 / R8 / R10: reset values, halt, back-to-back PRN cadence
      plen = 0;
      emit('h47); emit(7);
      emit('h47); emit(0);
      emit('h01);
      run_prog(1'b1);
      check("R1 output count", cap_n, 2);
      check("R1 R7 reset value", cap_d[0], 'hF4);
      check("R1 R0 reset value", cap_d[1], 0);
      check("R10 PRN spacing", cap_c[1] - cap_c[0], 4);
      check("R8 halted sticky", halted, 1);
      check("R8 HLT not illegal", illegal, 0);

      // R2: LDI into each of registers 0..6, then PRN each
      plen = 0;
      for (int r = 0; r < 7; r++) begin
         emit('h82); emit(r); emit(('h11 * r + 3) % 256);
      end
      for (int r = 0; r < 7; r++) begin
         emit('h47); emit(r);
      end
      emit('h01);
      run_prog(1'b0);
      check("R2 output count", cap_n, 7);
      for (int r = 0; r < 7; r++) check("R2 LDI/PRN value", cap_d[r], ('h11 * r + 3) % 256);

      // R3 / R10: ADD and MUL sweep
      for (int a = 0; a < 256; a += 15) begin
         for (int b = 0; b < 256; b += 13) begin
            plen = 0;
            emit('h82); emit(0); emit(a);
            emit('h82); emit(1); emit(b);
            emit('h82); emit(2); emit(a);
            emit('hA0); emit(0); emit(1);
            emit('h47); emit(0);
            emit('hA2); emit(2); emit(1);
            emit('h47); emit(2);
            emit('h01);
            run_prog(1'b0);
            check("R3 output count", cap_n, 2);
            check("R3 ADD wraps mod 256", cap_d[0], (a + b) % 256);
            check("R3 MUL wraps mod 256", cap_d[1], (a * b) % 256);
            check("R10 MUL+PRN takes 8 cycles", cap_c[1] - cap_c[0], 8);
         end
      end

      // R4: CMP with JEQ / JNE over corner values
      for (int jop = 'h55; jop <= 'h56; jop++) begin
         for (int ia = 0; ia < 7; ia++) begin
            for (int ib = 0; ib < 7; ib++) begin
               automatic int va = (ia == 0) ? 0 : (ia == 1) ? 1 : (ia == 2) ? 2 :
                                  (ia == 3) ? 127 : (ia == 4) ? 128 : (ia == 5) ? 254 : 255;
               automatic int vb = (ib == 0) ? 0 : (ib == 1) ? 1 : (ib == 2) ? 2 :
                                  (ib == 3) ? 127 : (ib == 4) ? 128 : (ib == 5) ? 254 : 255;
               automatic int exp_taken = (jop == 'h55) ? int'(va == vb) : int'(va != vb);
               plen = 0;
               emit('h82); emit(0); emit(va);
               emit('h82); emit(1); emit(vb);
               emit('h82); emit(2); emit(20);
               emit('hA7); emit(0); emit(1);
               emit(jop);  emit(2);
               emit('h82); emit(3); emit(0);
               emit('h47); emit(3);
               emit('h01);
               emit('h82); emit(3); emit(1);
               emit('h47); emit(3);
               emit('h01);
               run_prog(1'b0);
               check("R4 branch output count", cap_n, 1);
               check("R4 branch decision", cap_d[0], exp_taken);
            end
         end
      end

      // R4: a second CMP clears the equal flag left by the first
      plen = 0;
      emit('h82); emit(0); emit(5);
      emit('h82); emit(1); emit(5);
      emit('h82); emit(2); emit(6);
      emit('h82); emit(4); emit(26);
      emit('hA7); emit(0); emit(1);
      emit('hA7); emit(0); emit(2);
      emit('h55); emit(4);
      emit('h82); emit(3); emit(0);
      emit('h47); emit(3);
      emit('h01);
      emit('h82); emit(3); emit(1);
      emit('h47); emit(3);
      emit('h01);
      run_prog(1'b0);
      check("R4 flags cleared by CMP", cap_d[0], 0);

      // R5 / R6 / R10: stack, call and return
      for (int k = 0; k < 2; k++) begin
         automatic int va = (k == 0) ? 'h12 : 'hFF;
         automatic int vb = (k == 0) ? 'h34 : 'h00;
         plen = 0;
         emit('h82); emit(0); emit(va);
         emit('h82); emit(1); emit(vb);
         emit('h45); emit(0);
         emit('h45); emit(1);
         emit('h46); emit(2);
         emit('h46); emit(3);
         emit('h47); emit(2);
         emit('h47); emit(3);
         emit('h47); emit(7);
         emit('h82); emit(4); emit(30);
         emit('h50); emit(4);
         emit('h47); emit(5);
         emit('h01);
         emit(0); emit(0);
         emit('h82); emit(5); emit('h77);
         emit('h47); emit(7);
         emit('h11);
         run_prog(1'b0);
         check("R6 output count", cap_n, 5);
         check("R5 LIFO first pop", cap_d[0], vb);
         check("R5 LIFO second pop", cap_d[1], va);
         check("R5 SP restored", cap_d[2], 'hF4);
         check("R6 SP inside call", cap_d[3], 'hF3);
         check("R6 return to caller", cap_d[4], 'h77);
         check("R10 RET takes 5 cycles", cap_c[4] - cap_c[3], 9);
      end

      // R7: unconditional jump skips code
      plen = 0;
      emit('h82); emit(0); emit(9);
      emit('h54); emit(0);
      emit('h82); emit(1); emit('hAA);
      emit('h01);
      emit('h82); emit(1); emit('h55);
      emit('h47); emit(1);
      emit('h01);
      run_prog(1'b0);
      check("R7 output count", cap_n, 1);
      check("R7 JMP target", cap_d[0], 'h55);

      // R9: unknown opcodes stop the core
      for (int u = 0; u < 3; u++) begin
         automatic int bad = (u == 0) ? 'h00 : (u == 1) ? 'hFF : 'h12;
         plen = 0;
         emit('h47); emit(0);
         emit(bad);
         emit('h47); emit(0);
         emit('h01);
         run_prog(1'b0);
         check("R9 illegal flag", illegal, 1);
         check("R9 halted flag", halted, 1);
         check("R9 no later output", cap_n, 1);
      end

      finished = 1;
      summary();
      $finish;
   end

endmodule